// File: doc/BRIEF.md
# DMA Channel Enable Register Bank

This block keeps two per-channel bitmaps for a 64-channel DMA controller. The first is the error-interrupt enable, one bit per channel. The second is the hardware-request enable, one bit per channel. Software reaches both through a simple 32-bit register bus. Each bitmap appears as a high word and a low word that can be read and written whole. Next to these words sits a write-only word of four byte-wide command registers. Each command byte names one channel, or all channels at once, and sets or clears that channel's bit. This lets software change one channel without a read-modify-write.

Towards the transfer engine, the block drives the request-enable vector. It also drives a per-channel error interrupt vector, built from each channel's incoming error flag and its enable bit, and a combined interrupt that is the OR of all channels. The engine signals channel completion with a one-cycle pulse. A second per-channel input selects whether a completion should drop that channel's request enable. The bank then clears the bit on its own.

Every register update takes effect at the clock edge that samples the write, so it is visible from the next cycle. Reads are combinational while the read strobe is high.

Top module: `dma_chan_enable_regs`

## Requirements
- R1: After reset, both bitmaps read as zero, `req_en` is zero, and both interrupt outputs are low.
- R2: Word offset 0x10 holds error enables for channels 63..32, with bit n mapping to channel 32+n. Offset 0x14 holds channels 31..0, with bit n mapping to channel n. Offsets 0x08 and 0x0C map the request enables the same way. All four words are read/write.
- R3: A write to one of the four bitmap words updates only the byte lanes whose enable is high. Lane k covers data bits 8k+7..8k.
- R4: Offset 0x18 holds four command bytes. Lane 0 sets an error enable, lane 1 clears one, lane 2 sets a request enable and lane 3 clears one. In each byte, bits [5:0] give the channel. Bit 6 high means all 64 channels. Bit 7 is ignored. A set byte forces the selected bits to 1.
- R5: A clear byte forces the selected bits to 0. Channels that are not selected keep their value.
- R6: Reads of offset 0x18 return zero. Reads of offsets outside the four bitmap words also return zero.
- R7: If one write both sets and clears the same channel in the same bitmap, the bit ends at 0. A set and a clear that target different channels both take effect.
- R8: `err_irq[i]` is high exactly when `chan_err[i]` and error enable i are both high. `err_irq_any` is the OR of all 64 bits.
- R9: A cycle with `chan_done[i]` and `chan_done_dis[i]` both high clears request enable i at that edge. A `chan_done[i]` pulse with `chan_done_dis[i]` low leaves the bit unchanged.
- R10: If an automatic completion clear falls in the same cycle as a software write that sets the same request-enable bit, the bit ends at 0. This holds for both a word write and a set byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; read data is zero when low |
| bus_addr | input | 6 | Word address, byte address bits [7:2] |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_rdata | output | 32 | Read data, combinational |
| chan_err | input | 64 | Per-channel error flags |
| chan_done | input | 64 | Per-channel completion pulses |
| chan_done_dis | input | 64 | Per-channel option: completion clears the request enable |
| req_en | output | 64 | Hardware-request enable bitmap |
| err_irq | output | 64 | Per-channel error interrupt requests |
| err_irq_any | output | 1 | OR of all error interrupt requests |

## Verification
Two functions can land on the same request-enable bit in one cycle: the automatic clear from a completion with the disable option set, and a software write that sets the bit. The write may be either a bitmap word or a set byte. The bench provokes this directly and also through random completion pulses that overlap random register writes. A bench model gives the clear priority, and the request-enable output and the read-back are compared with it after each cycle. Set and clear bytes that target the same channel in one write are judged the same way.

// File: rtl/dce_pkg.sv
package dce_pkg;
  localparam int unsigned NUM_CH   = 64;
  localparam int unsigned BUS_W    = 32;
  localparam int unsigned LANES    = BUS_W / 8;
  localparam int unsigned WA_W     = 6;

  // word addresses (byte offset >> 2)
  localparam logic [WA_W-1:0] WA_REQ_HI = 6'h02;
  localparam logic [WA_W-1:0] WA_REQ_LO = 6'h03;
  localparam logic [WA_W-1:0] WA_ERR_HI = 6'h04;
  localparam logic [WA_W-1:0] WA_ERR_LO = 6'h05;
  localparam logic [WA_W-1:0] WA_CMD    = 6'h06;

  // command byte lanes within the command word
  typedef enum logic [1:0] {
    LANE_ERR_SET = 2'd0,
    LANE_ERR_CLR = 2'd1,
    LANE_REQ_SET = 2'd2,
    LANE_REQ_CLR = 2'd3
  } cmd_lane_e;
endpackage

// File: rtl/dce_chan_decode.sv
module dce_chan_decode #(
  parameter int unsigned NCH = 64,
  localparam int unsigned CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           valid,
  input  logic [CW:0]    cmd,     // [CW] all-channels, [CW-1:0] channel
  output logic [NCH-1:0] mask
);
  logic all_sel;
  logic [CW-1:0] ch_sel;

  assign all_sel = cmd[CW];
  assign ch_sel  = cmd[CW-1:0];

  for (genvar i = 0; i < NCH; i++) begin : g_bit
    assign mask[i] = valid & (all_sel | (ch_sel == CW'(i)));
  end

  // R4: a command selects nothing, one channel, or every channel
  a_r4_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(mask) <= 1) || (&mask));
endmodule

// File: rtl/dce_bitmap_reg.sv
module dce_bitmap_reg #(
  parameter int unsigned NCH = 64,
  localparam int unsigned HALF = NCH / 2,
  localparam int unsigned NL   = HALF / 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_hi,
  input  logic            wr_lo,
  input  logic [HALF-1:0] wdata,
  input  logic [NL-1:0]   be,
  input  logic [NCH-1:0]  set_mask,
  input  logic [NCH-1:0]  clr_mask,
  input  logic [NCH-1:0]  auto_clr,
  output logic [NCH-1:0]  q
);
  logic [HALF-1:0] lane_mask;
  logic [NCH-1:0]  word_mask;
  logic [NCH-1:0]  q_nxt;
  logic            q_en;

  for (genvar k = 0; k < NL; k++) begin : g_lane
    assign lane_mask[8*k +: 8] = {8{be[k]}};
  end

  assign word_mask = {(wr_hi ? lane_mask : '0), (wr_lo ? lane_mask : '0)};

  // priority, lowest first: word write, set, clear, completion clear
  always_comb begin
    q_nxt = (q & ~word_mask) | ({wdata, wdata} & word_mask);
    q_nxt = q_nxt | set_mask;
    q_nxt = q_nxt & ~clr_mask;
    q_nxt = q_nxt & ~auto_clr;
  end

  assign q_en = (|word_mask) | (|set_mask) | (|clr_mask) | (|auto_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_nxt;
  end

  // R4: a set not overridden lands as 1
  a_r4_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_mask & ~clr_mask & ~auto_clr)) |=>
    ((q & $past(set_mask & ~clr_mask & ~auto_clr)) == $past(set_mask & ~clr_mask & ~auto_clr)));

  // R5/R7/R10: clear and completion clear always win
  a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_mask | auto_clr)) |=> ((q & $past(clr_mask | auto_clr)) == '0));

  // R3: no activity, no change
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hi && !wr_lo && set_mask == '0 && clr_mask == '0 && auto_clr == '0) |=> $stable(q));
endmodule

// File: rtl/dce_irq_combine.sv
module dce_irq_combine #(
  parameter int unsigned NCH = 64
) (
  input  logic [NCH-1:0] flag,
  input  logic [NCH-1:0] enable,
  output logic [NCH-1:0] irq,
  output logic           irq_any
);
  assign irq     = flag & enable;
  assign irq_any = |irq;
endmodule

// File: rtl/dma_chan_enable_regs.sv
module dma_chan_enable_regs
  import dce_pkg::*;
#(
  parameter int unsigned NCH = NUM_CH,
  localparam int unsigned HALF = NCH / 2,
  localparam int unsigned NL   = HALF / 8,
  localparam int unsigned CW   = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [7:2]      bus_addr,
  input  logic [HALF-1:0] bus_wdata,
  input  logic [NL-1:0]   bus_be,
  output logic [HALF-1:0] bus_rdata,
  input  logic [NCH-1:0]  chan_err,
  input  logic [NCH-1:0]  chan_done,
  input  logic [NCH-1:0]  chan_done_dis,
  output logic [NCH-1:0]  req_en,
  output logic [NCH-1:0]  err_irq,
  output logic            err_irq_any
);
  // reset: asserted asynchronously, released on the clock
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  logic wr_req_hi, wr_req_lo, wr_err_hi, wr_err_lo, wr_cmd;
  assign wr_req_hi = bus_wr && (bus_addr == WA_REQ_HI);
  assign wr_req_lo = bus_wr && (bus_addr == WA_REQ_LO);
  assign wr_err_hi = bus_wr && (bus_addr == WA_ERR_HI);
  assign wr_err_lo = bus_wr && (bus_addr == WA_ERR_LO);
  assign wr_cmd    = bus_wr && (bus_addr == WA_CMD);

  // one decoder per command byte lane
  logic [NCH-1:0] lane_mask [4];
  for (genvar k = 0; k < 4; k++) begin : g_cmd
    dce_chan_decode #(.NCH(NCH)) u_dec (
      .clk   (clk),
      .rst_n (rst_s2),
      .valid (wr_cmd & bus_be[k]),
      .cmd   (bus_wdata[8*k +: CW+1]),
      .mask  (lane_mask[k])
    );
  end

  logic [NCH-1:0] err_en, auto_clr;
  assign auto_clr = chan_done & chan_done_dis;

  dce_bitmap_reg #(.NCH(NCH)) u_err_map (
    .clk      (clk),
    .rst_n    (rst_s2),
    .wr_hi    (wr_err_hi),
    .wr_lo    (wr_err_lo),
    .wdata    (bus_wdata),
    .be       (bus_be),
    .set_mask (lane_mask[LANE_ERR_SET]),
    .clr_mask (lane_mask[LANE_ERR_CLR]),
    .auto_clr ('0),
    .q        (err_en)
  );

  dce_bitmap_reg #(.NCH(NCH)) u_req_map (
    .clk      (clk),
    .rst_n    (rst_s2),
    .wr_hi    (wr_req_hi),
    .wr_lo    (wr_req_lo),
    .wdata    (bus_wdata),
    .be       (bus_be),
    .set_mask (lane_mask[LANE_REQ_SET]),
    .clr_mask (lane_mask[LANE_REQ_CLR]),
    .auto_clr (auto_clr),
    .q        (req_en)
  );

  dce_irq_combine #(.NCH(NCH)) u_irq (
    .flag    (chan_err),
    .enable  (err_en),
    .irq     (err_irq),
    .irq_any (err_irq_any)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        WA_REQ_HI: bus_rdata = req_en[NCH-1:HALF];
        WA_REQ_LO: bus_rdata = req_en[HALF-1:0];
        WA_ERR_HI: bus_rdata = err_en[NCH-1:HALF];
        WA_ERR_LO: bus_rdata = err_en[HALF-1:0];
        default:   bus_rdata = '0;
      endcase
    end
  end

  // R8: combined interrupt needs a flagged, enabled channel
  a_r8_any_has_source: assert property (@(posedge clk) disable iff (!rst_s2)
    err_irq_any |-> (|(chan_err & err_en)));

  // R9: completion with the option set drops the request enable
  a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_s2)
    (|(chan_done & chan_done_dis)) |=> ((req_en & $past(chan_done & chan_done_dis)) == '0));

  // R6: command word never reads back
  a_r6_cmd_reads_zero: assert property (@(posedge clk) disable iff (!rst_s2)
    (bus_rd && bus_addr == WA_CMD) |-> (bus_rdata == '0));
endmodule

// File: tb/dma_chan_enable_regs_test.sv
`timescale 1ns/1ps
module dma_chan_enable_regs_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [7:2]  bus_addr;
  logic [31:0] bus_wdata;
  logic [3:0]  bus_be;
  logic [31:0] bus_rdata;
  logic [63:0] chan_err, chan_done, chan_done_dis;
  logic [63:0] req_en, err_irq;
  logic        err_irq_any;

  int checks = 0;
  int fails  = 0;
  logic [63:0] m_err, m_req;

  always #2.5 clk = ~clk;

  dma_chan_enable_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_rdata(bus_rdata), .chan_err(chan_err), .chan_done(chan_done),
    .chan_done_dis(chan_done_dis), .req_en(req_en), .err_irq(err_irq),
    .err_irq_any(err_irq_any)
  );

  function automatic logic [63:0] cmd_mask(input logic v, input logic [7:0] b);
    if (!v) return '0;
    if (b[6]) return '1;
    return 64'd1 << b[5:0];
  endfunction

  function automatic logic [63:0] upd(input logic [63:0] cur, input logic hi, input logic lo,
                                      input logic [31:0] d, input logic [3:0] be,
                                      input logic [63:0] s, input logic [63:0] c,
                                      input logic [63:0] a);
    logic [63:0] n = cur;
    for (int k = 0; k < 4; k++) begin
      if (be[k] && hi) n[32+8*k +: 8] = d[8*k +: 8];
      if (be[k] && lo) n[8*k +: 8]    = d[8*k +: 8];
    end
    n = (n | s) & ~c & ~a;
    return n;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_outputs(input string req);
    chk({req, " req_en"}, req_en, m_req);
    chk({req, " err_irq"}, err_irq, chan_err & m_err);
    chk({req, " err_irq_any"}, {63'd0, err_irq_any}, {63'd0, |(chan_err & m_err)});
  endtask

  task automatic step(input logic wr, input logic [7:2] a, input logic [31:0] d,
                      input logic [3:0] be, input logic [63:0] dn, input logic [63:0] op);
    logic cmd;
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; bus_be = be;
    chan_done = dn; chan_done_dis = op;
    cmd = wr && (a == 6'h06);
    m_err = upd(m_err, wr && a == 6'h04, wr && a == 6'h05, d, be,
                cmd_mask(cmd && be[0], d[7:0]), cmd_mask(cmd && be[1], d[15:8]), '0);
    m_req = upd(m_req, wr && a == 6'h02, wr && a == 6'h03, d, be,
                cmd_mask(cmd && be[2], d[23:16]), cmd_mask(cmd && be[3], d[31:24]), dn & op);
    @(posedge clk);
    #1;
    bus_wr = 1'b0; chan_done = '0;
  endtask

  task automatic rd_chk(input string req, input logic [7:2] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #0.5;
    chk(req, {32'd0, bus_rdata}, {32'd0, exp});
    bus_rd = 1'b0;
  endtask

  task automatic rd_all(input string req);
    rd_chk(req, 6'h02, m_req[63:32]);
    rd_chk(req, 6'h03, m_req[31:0]);
    rd_chk(req, 6'h04, m_err[63:32]);
    rd_chk(req, 6'h05, m_err[31:0]);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0; bus_be = '0;
    chan_err = '0; chan_done = '0; chan_done_dis = '0;
    m_err = '0; m_req = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chan_err = '1;
    #0.5;
    chk_outputs("R1");
    rd_all("R1");

    // R2 whole-word writes, bit mapping
    step(1, 6'h04, 32'hA5A5_0001, 4'hF, '0, '0);
    step(1, 6'h05, 32'h8000_0010, 4'hF, '0, '0);
    step(1, 6'h02, 32'h1234_5678, 4'hF, '0, '0);
    step(1, 6'h03, 32'h0000_0003, 4'hF, '0, '0);
    chk_outputs("R2");
    chk("R2 ch32", {63'd0, err_irq[32]}, 64'd1);
    chk("R2 ch31", {63'd0, err_irq[31]}, 64'd1);
    rd_all("R2");

    // R3 byte lanes
    step(1, 6'h05, 32'hFFFF_FFFF, 4'b0010, '0, '0);
    step(1, 6'h02, 32'h0000_0000, 4'b1001, '0, '0);
    chk_outputs("R3");
    rd_all("R3");

    // R4 set bytes: single channel, all channels, bit7 ignored
    step(1, 6'h06, 32'h0000_0005, 4'b0001, '0, '0);
    step(1, 6'h06, 32'h0028_0000, 4'b0100, '0, '0);
    step(1, 6'h06, 32'h0000_00B0, 4'b0001, '0, '0);
    chk_outputs("R4");
    chk("R4 ch5", {63'd0, err_irq[5]}, 64'd1);
    step(1, 6'h06, 32'h0000_0040, 4'b0001, '0, '0);
    chk("R4 all", err_irq, '1);
    rd_all("R4");

    // R5 clear bytes
    step(1, 6'h06, 32'h0000_2100, 4'b0010, '0, '0);
    step(1, 6'h06, 32'h4000_0000, 4'b1000, '0, '0);
    chk_outputs("R5");
    chk("R5 ch33", {63'd0, err_irq[33]}, 64'd0);
    rd_all("R5");

    // R6 command word and unmapped reads return zero
    rd_chk("R6 cmd", 6'h06, 32'd0);
    rd_chk("R6 unmapped", 6'h07, 32'd0);
    rd_chk("R6 unmapped", 6'h00, 32'd0);

    // R7 set and clear in one write
    step(1, 6'h06, 32'h0000_0707, 4'b0011, '0, '0);
    chk("R7 same ch", {63'd0, err_irq[7]}, 64'd0);
    step(1, 6'h06, 32'h0000_0807, 4'b0011, '0, '0);
    chk_outputs("R7");
    step(1, 6'h06, 32'h0909_0000, 4'b1100, '0, '0);
    chk("R7 req same ch", {63'd0, req_en[9]}, 64'd0);

    // R9 completion with and without option
    step(1, 6'h03, 32'hFFFF_FFFF, 4'hF, '0, '0);
    step(0, 6'h00, 0, 0, 64'h0000_0000_0000_0030, 64'h0000_0000_0000_0010);
    chk_outputs("R9");
    chk("R9 opt", {62'd0, req_en[5:4]}, 64'd2);

    // R10 completion clear versus a set byte and a word write
    step(1, 6'h06, 32'h000C_0000, 4'b0100, 64'h1000, 64'h1000);
    chk("R10 set byte", {63'd0, req_en[12]}, 64'd0);
    step(1, 6'h03, 32'hFFFF_FFFF, 4'hF, 64'h8, 64'h8);
    chk("R10 word", {63'd0, req_en[3]}, 64'd0);
    chk_outputs("R10");
    rd_all("R10");

    // random mix
    for (int it = 0; it < 400; it++) begin
      logic [2:0] op = 3'($urandom_range(0, 5));
      logic [7:2] a;
      logic [31:0] d = $urandom;
      logic [63:0] dn = {$urandom, $urandom} & {$urandom, $urandom};
      logic [63:0] dd = {$urandom, $urandom};
      chan_err = {$urandom, $urandom};
      case (op)
        3'd0: a = 6'h02;
        3'd1: a = 6'h03;
        3'd2: a = 6'h04;
        3'd3: a = 6'h05;
        default: a = 6'h06;
      endcase
      if (op == 3'd5) d = d & 32'h3F3F_3F3F;
      step(($urandom % 5) != 0, a, d, 4'($urandom), ($urandom % 2) ? dn : '0, dd);
      chk_outputs("R10 random");
      if (it % 8 == 0) rd_all("R2 random");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule